// File: doc/BRIEF.md
# Sampling converter start/capture sequencer

This block runs a 14-bit edge-triggered sampling converter from the system clock. It drives the converter's start line, watches the busy line that the converter holds high while a conversion is in progress, and latches the parallel result once the busy line has dropped and the bus has had time to settle. Each captured word leaves the block on a valid/ready stream together with a flag that marks the sample as untrustworthy.

A conversion is requested either by a one-cycle `trig` pulse or, while `run` is high, automatically every `cfg_period` clock cycles. Free-running mode is what the converter needs during warm-up, when it must convert without pause. The start pulse width, the settling delay and the busy timeout are given in clock cycles on configuration inputs. At a 100 MHz clock the usual settings are 100 for the period (1 MHz), 20 for the pulse (200 ns) and 4 for the settling delay (covering the 35 ns data delay). The block never raises the start line while the busy line is high. A request that arrives in that window is held, counted, and issued once the line drops.

The controller has five states. IDLE waits for a request. DEFER holds a request while busy is high. PULSE drives the start line high. BUSY waits for busy to rise and then fall. SETTLE counts the settling delay and then captures the word. The transitions are: IDLE to PULSE (request, busy low, low-time met); IDLE to DEFER (request while busy high); DEFER to PULSE (busy low and low-time met); PULSE to BUSY (pulse width reached); BUSY to SETTLE (busy fell after being seen high); BUSY to IDLE (timeout); SETTLE to IDLE (delay over, word captured).

Top module: `adc_seq`

## Requirements
- R1: After reset, `start_o` is low, `m_valid` is low, `ovr_flag` and `tmo_flag` are clear, and `defer_cnt` is zero.
- R2: The start pulse stays high for exactly max(`cfg_pulse`, MIN_W) cycles, and the start line stays low for at least MIN_W cycles between pulses.
- R3: While `run` is high and each conversion completes within the period, rising edges of `start_o` are exactly `cfg_period` cycles apart. A `trig` pulse requests exactly one conversion.
- R4: `start_o` never rises while the synchronised busy line is high. A request made then is held, `defer_cnt` increments by one, and the pulse is issued after busy goes low.
- R5: The data word is latched 2 synchroniser cycles plus `cfg_settle` cycles after busy falls, and is passed unchanged as 14-bit straight binary: 0x0000 is zero input and 0x3FFF is full scale minus one step.
- R6: `m_bad` is set when busy was high for fewer than MIN_CONV cycles in that conversion. A conversion with exactly MIN_CONV cycles is good.
- R7: A rise of busy that the block did not cause marks the next two captured samples as bad.
- R8: If busy has not fallen `cfg_timeout` cycles after the pulse started, `tmo_flag` sets and stays set until reset, no sample is produced, and the block returns to IDLE and accepts new requests.
- R9: `m_valid` and `m_data` hold until `m_ready` is seen. A capture that lands while the stream is stalled sets the sticky `ovr_flag` and replaces the word with the newer one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Free-running conversion enable |
| trig | input | 1 | One-cycle single conversion request |
| cfg_period | input | CW | Sample period in cycles |
| cfg_pulse | input | CW | Requested start pulse width in cycles |
| cfg_settle | input | SW | Extra cycles between busy falling and capture |
| cfg_timeout | input | CW | Busy timeout in cycles from pulse start |
| start_o | output | 1 | Start-convert line to the converter |
| eoc | input | 1 | Busy line from the converter, asynchronous |
| adc_d | input | DW | Converter parallel data, straight binary |
| m_valid | output | 1 | Sample available |
| m_ready | input | 1 | Consumer accepts sample |
| m_data | output | DW | Captured sample |
| m_bad | output | 1 | Sample came from a short or disturbed conversion |
| ovr_flag | output | 1 | Sticky: a sample was overwritten while stalled |
| tmo_flag | output | 1 | Sticky: busy never fell in time |
| defer_cnt | output | DCW | Number of requests held back by busy |

## Verification
The main capture path is exercised with the two extreme codes, with random words and random busy lengths on both sides of MIN_CONV, and with random pulse widths below and above the minimum. These tests separate correct capture and flagging from off-by-one counting of the conversion length and from a missing pulse clamp. The behavioural converter keeps the inverted word on the bus for five cycles after busy falls, so any capture made before the settling delay shows up as a wrong word. Separate directed runs cover an unsolicited busy pulse (deferral and two tainted samples), a silent converter (timeout and recovery), free running (period spacing) and a stalled consumer (overrun keeping the newer word).

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_DEFER,
        S_PULSE,
        S_BUSY,
        S_SETTLE
    } seq_state_t;
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else begin
            sh[0] <= d;
            for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
        end
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/adc_seq_ctl.sv
module adc_seq_ctl
    import adc_seq_pkg::*;
#(
    parameter int CW       = 16,
    parameter int SW       = 8,
    parameter int DCW      = 8,
    parameter int MIN_W    = 2,
    parameter int MIN_CONV = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           trig,
    input  logic [CW-1:0]  cfg_period,
    input  logic [CW-1:0]  cfg_pulse,
    input  logic [SW-1:0]  cfg_settle,
    input  logic [CW-1:0]  cfg_timeout,
    input  logic           eoc_s,
    output logic           start_o,
    output logic           cap_en,
    output logic           cap_bad,
    output logic           tmo_flag,
    output logic [DCW-1:0] defer_cnt
);
    localparam logic [CW-1:0] MIN_W_C    = CW'(MIN_W);
    localparam logic [CW-1:0] LO_LOAD    = CW'(MIN_W - 1);
    localparam logic [CW-1:0] MIN_CONV_C = CW'(MIN_CONV);

    seq_state_t st, st_nx;
    logic [CW-1:0] hi_cnt, lo_cnt, per_cnt, tmo_cnt, conv_len;
    logic [SW-1:0] set_cnt;
    logic [1:0]    taint;
    logic          trig_pend, seen_hi, eoc_q;
    logic [CW-1:0] width_eff;
    logic          req, low_ok, enter_pulse, converting;

    assign width_eff   = (cfg_pulse < MIN_W_C) ? MIN_W_C : cfg_pulse;
    assign req         = trig_pend | (run & (per_cnt == '0));
    assign low_ok      = (lo_cnt == '0);
    assign enter_pulse = (st != S_PULSE) && (st_nx == S_PULSE);
    assign converting  = (st == S_PULSE) || (st == S_BUSY);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:   if (req) begin
                          if (eoc_s)       st_nx = S_DEFER;
                          else if (low_ok) st_nx = S_PULSE;
                      end
            S_DEFER:  if (!eoc_s && low_ok) st_nx = S_PULSE;
            S_PULSE:  if (hi_cnt <= CW'(1)) st_nx = S_BUSY;
            S_BUSY:   if (seen_hi && !eoc_s)           st_nx = S_SETTLE;
                      else if (tmo_cnt >= cfg_timeout) st_nx = S_IDLE;
            S_SETTLE: if (set_cnt == '0) st_nx = S_IDLE;
            default:  st_nx = S_IDLE;
        endcase
    end

    // counters and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt    <= '0;
            lo_cnt    <= '0;
            per_cnt   <= '0;
            tmo_cnt   <= '0;
            conv_len  <= '0;
            set_cnt   <= '0;
            taint     <= '0;
            trig_pend <= 1'b0;
            seen_hi   <= 1'b0;
            eoc_q     <= 1'b0;
            tmo_flag  <= 1'b0;
            defer_cnt <= '0;
        end else begin
            eoc_q <= eoc_s;
            if (enter_pulse) trig_pend <= 1'b0;
            if (trig)        trig_pend <= 1'b1;

            if (enter_pulse)
                per_cnt <= (cfg_period == '0) ? '0 : cfg_period - CW'(1);
            else if (per_cnt != '0)
                per_cnt <= per_cnt - CW'(1);

            if (enter_pulse)        hi_cnt <= width_eff;
            else if (st == S_PULSE) hi_cnt <= hi_cnt - CW'(1);

            if (st == S_PULSE && st_nx != S_PULSE) lo_cnt <= LO_LOAD;
            else if (lo_cnt != '0)                 lo_cnt <= lo_cnt - CW'(1);

            if (enter_pulse) begin
                tmo_cnt  <= '0;
                conv_len <= '0;
                seen_hi  <= 1'b0;
            end else if (converting) begin
                if (tmo_cnt != '1) tmo_cnt <= tmo_cnt + CW'(1);
                if (eoc_s) begin
                    seen_hi <= 1'b1;
                    if (conv_len != '1) conv_len <= conv_len + CW'(1);
                end
            end

            if (st != S_SETTLE && st_nx == S_SETTLE) set_cnt <= cfg_settle;
            else if (st == S_SETTLE && set_cnt != '0) set_cnt <= set_cnt - SW'(1);

            if (st == S_BUSY && st_nx == S_IDLE)  tmo_flag  <= 1'b1;
            if (st == S_IDLE && st_nx == S_DEFER) defer_cnt <= defer_cnt + DCW'(1);

            if (eoc_s && !eoc_q && !converting) taint <= 2'd2;
            else if (cap_en && taint != '0)     taint <= taint - 2'd1;
        end
    end

    // outputs
    always_comb begin
        start_o = (st == S_PULSE);
        cap_en  = (st == S_SETTLE) && (set_cnt == '0);
        cap_bad = (taint != '0) || (conv_len < MIN_CONV_C);
    end

    // run-length counters used by the width checks
    logic [CW-1:0] hi_run, lo_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= MIN_W_C;
        end else if (start_o) begin
            if (hi_run != '1) hi_run <= hi_run + CW'(1);
            lo_run <= '0;
        end else begin
            hi_run <= '0;
            if (lo_run != '1) lo_run <= lo_run + CW'(1);
        end
    end

    // R2
    pulse_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_o) |-> hi_run >= MIN_W_C);
    // R2
    pulse_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_o) |-> lo_run >= MIN_W_C);
    // R4
    no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_o) |-> !eoc_s);
    // R5
    cap_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> !eoc_s);
    // R8
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_flag |=> tmo_flag);
endmodule

// File: rtl/adc_seq_out.sv
module adc_seq_out #(
    parameter int DW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [DW-1:0] cap_data,
    input  logic          cap_bad,
    input  logic          m_ready,
    output logic          m_valid,
    output logic [DW-1:0] m_data,
    output logic          m_bad,
    output logic          ovr_flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_valid  <= 1'b0;
            m_data   <= '0;
            m_bad    <= 1'b0;
            ovr_flag <= 1'b0;
        end else if (cap_en) begin
            if (m_valid && !m_ready) ovr_flag <= 1'b1;
            m_valid <= 1'b1;
            m_data  <= cap_data;
            m_bad   <= cap_bad;
        end else if (m_ready) begin
            m_valid <= 1'b0;
        end
    end

    // R9
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready && !cap_en |=> m_valid && $stable(m_data));
    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag |=> ovr_flag);
endmodule

// File: rtl/adc_seq.sv
module adc_seq #(
    parameter int DW       = 14,
    parameter int CW       = 16,
    parameter int SW       = 8,
    parameter int DCW      = 8,
    parameter int MIN_W    = 2,
    parameter int MIN_CONV = 32,
    parameter int SYNC     = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           trig,
    input  logic [CW-1:0]  cfg_period,
    input  logic [CW-1:0]  cfg_pulse,
    input  logic [SW-1:0]  cfg_settle,
    input  logic [CW-1:0]  cfg_timeout,
    output logic           start_o,
    input  logic           eoc,
    input  logic [DW-1:0]  adc_d,
    output logic           m_valid,
    input  logic           m_ready,
    output logic [DW-1:0]  m_data,
    output logic           m_bad,
    output logic           ovr_flag,
    output logic           tmo_flag,
    output logic [DCW-1:0] defer_cnt
);
    logic eoc_s, cap_en, cap_bad;

    adc_seq_sync #(.STAGES(SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(eoc), .q(eoc_s)
    );

    adc_seq_ctl #(
        .CW(CW), .SW(SW), .DCW(DCW), .MIN_W(MIN_W), .MIN_CONV(MIN_CONV)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .run(run), .trig(trig),
        .cfg_period(cfg_period), .cfg_pulse(cfg_pulse),
        .cfg_settle(cfg_settle), .cfg_timeout(cfg_timeout),
        .eoc_s(eoc_s), .start_o(start_o), .cap_en(cap_en),
        .cap_bad(cap_bad), .tmo_flag(tmo_flag), .defer_cnt(defer_cnt)
    );

    adc_seq_out #(.DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_data(adc_d),
        .cap_bad(cap_bad), .m_ready(m_ready), .m_valid(m_valid),
        .m_data(m_data), .m_bad(m_bad), .ovr_flag(ovr_flag)
    );
endmodule

// File: tb/sim_adc_seq.sv
`timescale 1ns/1ps
module sim_adc_seq;
    localparam int MIN_W    = 4;
    localparam int MIN_CONV = 12;
    localparam int DATA_DLY = 5;

    logic        clk = 1'b0;
    logic        rst_n, run, trig, m_ready, eoc;
    logic [13:0] adc_d;
    logic [15:0] cfg_period, cfg_pulse, cfg_timeout;
    logic [7:0]  cfg_settle;
    logic        start_o, m_valid, m_bad, ovr_flag, tmo_flag;
    logic [13:0] m_data;
    logic [7:0]  defer_cnt;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    adc_seq #(.MIN_W(MIN_W), .MIN_CONV(MIN_CONV)) u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .trig(trig),
        .cfg_period(cfg_period), .cfg_pulse(cfg_pulse),
        .cfg_settle(cfg_settle), .cfg_timeout(cfg_timeout),
        .start_o(start_o), .eoc(eoc), .adc_d(adc_d),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .m_bad(m_bad), .ovr_flag(ovr_flag), .tmo_flag(tmo_flag),
        .defer_cnt(defer_cnt)
    );

    // behavioural converter
    bit          model_en = 1'b1;
    logic [13:0] conv_val = '0;
    int          conv_len = 16;

    initial begin
        forever begin
            @(posedge start_o);
            if (model_en) begin
                repeat (3) @(negedge clk);
                eoc = 1'b1;
                adc_d = ~conv_val;
                repeat (conv_len) @(negedge clk);
                eoc = 1'b0;
                repeat (DATA_DLY) @(negedge clk);
                adc_d = conv_val;
            end
        end
    end

    function automatic int exp_width(input int p);
        return (p < MIN_W) ? MIN_W : p;
    endfunction

    function automatic bit exp_bad(input int len, input int taint);
        return (taint > 0) || (len < MIN_CONV);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic fire(input logic [13:0] v, input int len, input bit do_trig,
                        output int width);
        conv_val = v;
        conv_len = len;
        if (do_trig) begin
            @(negedge clk); trig = 1'b1;
            @(negedge clk); trig = 1'b0;
        end
        width = 0;
        for (int i = 0; i < 300 && !start_o; i++) @(negedge clk);
        while (start_o) begin width++; @(negedge clk); end
    endtask

    task automatic take(output logic [13:0] d, output logic b, output bit got);
        got = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (m_valid) begin got = 1'b1; break; end
        end
        d = m_data;
        b = m_bad;
        m_ready = 1'b1;
        @(negedge clk);
        m_ready = 1'b0;
    endtask

    task automatic wait_rise(output int cycles);
        logic prev;
        cycles = 0;
        prev = start_o;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            cycles++;
            if (start_o && !prev) break;
            prev = start_o;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int w, cyc, tn, len, p;
        logic [13:0] d, v;
        logic b;
        bit got, seen;
        int unsigned seed;

        seed = $urandom(77);
        rst_n = 1'b0; run = 1'b0; trig = 1'b0; m_ready = 1'b0;
        eoc = 1'b0; adc_d = '0;
        cfg_period = 16'd60; cfg_pulse = 16'd10; cfg_settle = 8'd6;
        cfg_timeout = 16'd100;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(start_o == 1'b0, "R1 start", start_o, 0);
        chk(m_valid == 1'b0, "R1 valid", m_valid, 0);
        chk(ovr_flag == 1'b0, "R1 ovr", ovr_flag, 0);
        chk(tmo_flag == 1'b0, "R1 tmo", tmo_flag, 0);
        chk(defer_cnt == 8'd0, "R1 defer", defer_cnt, 0);

        // R5 extreme codes, R2 nominal width
        fire(14'h0000, 16, 1'b1, w);
        chk(w == 10, "R2 width", w, 10);
        take(d, b, got);
        chk(got && d == 14'h0000, "R5 zero code", d, 0);
        chk(b == 1'b0, "R6 good", b, 0);
        fire(14'h3FFF, 16, 1'b1, w);
        take(d, b, got);
        chk(got && d == 14'h3FFF, "R5 full scale", d, 14'h3FFF);

        // R2 clamp to minimum width
        cfg_pulse = 16'd1;
        fire(14'h0155, 16, 1'b1, w);
        chk(w == MIN_W, "R2 clamp", w, MIN_W);
        take(d, b, got);
        cfg_pulse = 16'd10;

        // R6 boundary on conversion length
        fire(14'h0AAA, MIN_CONV, 1'b1, w);
        take(d, b, got);
        chk(got && b == 1'b0, "R6 exact min", b, 0);
        fire(14'h0AAA, MIN_CONV - 1, 1'b1, w);
        take(d, b, got);
        chk(got && b == 1'b1, "R6 short", b, 1);

        // random captures: R2 R5 R6
        for (int k = 0; k < 16; k++) begin
            v = 14'($urandom);
            len = 8 + int'($urandom % 20);
            p = 1 + int'($urandom % 15);
            cfg_pulse = 16'(p);
            fire(v, len, 1'b1, w);
            chk(w == exp_width(p), "R2 rand width", w, exp_width(p));
            take(d, b, got);
            chk(got && d == v, "R5 rand data", d, v);
            chk(b == exp_bad(len, 0), "R6 rand flag", b, exp_bad(len, 0));
        end
        cfg_pulse = 16'd10;
        chk(ovr_flag == 1'b0, "R9 no ovr", ovr_flag, 0);

        // R4 deferral, R7 taint
        @(negedge clk); eoc = 1'b1;
        repeat (4) @(negedge clk);
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (start_o) seen = 1'b1; end
        chk(!seen, "R4 held", seen, 0);
        chk(defer_cnt == 8'd1, "R4 count", defer_cnt, 1);
        eoc = 1'b0;
        fire(14'h1111, 16, 1'b0, w);
        chk(w == 10, "R4 issued", w, 10);
        take(d, b, got);
        chk(got && d == 14'h1111, "R4 data", d, 14'h1111);
        chk(b == exp_bad(16, 2), "R7 first", b, 1);
        fire(14'h2222, 16, 1'b1, w);
        take(d, b, got);
        chk(b == exp_bad(16, 1), "R7 second", b, 1);
        fire(14'h3333, 16, 1'b1, w);
        take(d, b, got);
        chk(b == exp_bad(16, 0), "R7 cleared", b, 0);

        // R8 timeout
        model_en = 1'b0;
        fire(14'h0F0F, 16, 1'b1, w);
        repeat (50) @(negedge clk);
        chk(tmo_flag == 1'b0, "R8 early", tmo_flag, 0);
        repeat (100) @(negedge clk);
        chk(tmo_flag == 1'b1, "R8 flag", tmo_flag, 1);
        chk(m_valid == 1'b0, "R8 no sample", m_valid, 0);
        model_en = 1'b1;
        fire(14'h0BCD, 16, 1'b1, w);
        take(d, b, got);
        chk(got && d == 14'h0BCD, "R8 recover", d, 14'h0BCD);
        chk(tmo_flag == 1'b1, "R8 sticky", tmo_flag, 1);

        // R3 free running
        m_ready = 1'b1;
        conv_len = 16;
        run = 1'b1;
        wait_rise(cyc);
        for (int k = 0; k < 3; k++) begin
            wait_rise(tn);
            chk(tn == 60, "R3 period", tn, 60);
        end
        run = 1'b0;
        repeat (100) @(negedge clk);
        m_ready = 1'b0;
        chk(ovr_flag == 1'b0, "R9 ready no ovr", ovr_flag, 0);
        chk(start_o == 1'b0, "R3 stopped", start_o, 0);

        // R9 stall and overrun
        fire(14'h1234, 16, 1'b1, w);
        repeat (60) @(negedge clk);
        chk(m_valid && m_data == 14'h1234, "R9 hold", m_data, 14'h1234);
        fire(14'h0ABC, 16, 1'b1, w);
        repeat (60) @(negedge clk);
        chk(ovr_flag == 1'b1, "R9 ovr", ovr_flag, 1);
        chk(m_data == 14'h0ABC, "R9 newest", m_data, 14'h0ABC);
        take(d, b, got);
        @(negedge clk);
        chk(m_valid == 1'b0, "R9 drained", m_valid, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule